// File: doc/BRIEF.md
# Single-Channel PWM Timer with Atomic Update Lock

The block produces one pulse-width-modulated output from a free-running counter that counts input clock cycles directly, without a prescaler. Software reaches it through a small word-addressed register port with four locations: a read-only counter view, a period value, a duty value and a control word. The output is left-aligned and continuous: each period begins in the active level and moves to the inactive level once the counter reaches the duty value. The control word sets the two levels separately.

Period, duty and polarity written by software never reach the compare logic straight away. They wait in pending storage and move into the working set only on a period boundary, so every period on the output is whole and uses one consistent setting. A lock bit in the control word holds back that move. Software sets lock and keeps the old polarity, writes the new period and duty, then clears lock and writes the new polarity in the same control write. All three values then start together on the first cycle of the next period, and the output stays enabled throughout.

Top module: `pwm_lock_timer`

## Requirements
- R1: After reset, all three registers and the counter read zero, and the output is low.
- R2: The register locations are: counter at byte offset 0x0 (read-only, writes ignored), period at 0x4, duty at 0x8, control at 0xC. Period, duty and control read back the last value written.
- R3: In the control word, bit 0 is enable, bits 2:1 are the mode, bit 3 is the active level, bit 4 is the inactive level and bit 6 is lock. Bits 5, 7 and 8 and above always read 0 and ignore writes. This fixes left alignment and normal power operation.
- R4: The channel runs only when bit 0 is 1 and bits 2:1 equal 2'b01 (continuous). Otherwise the counter is held at 0 and the output drives control bit 4.
- R5: While running, the counter steps by one on each clock from 0 up to period-1 and then wraps to 0. A working period of 0 or 1 keeps the counter at 0.
- R6: While running, the output equals the working active level while counter < working duty, and the working inactive level otherwise. A duty of 0 gives a constant inactive output, and a duty greater than or equal to the period gives a constant active output.
- R7: With lock clear, a written period, duty or polarity enters the working set only on a period wrap, or on any cycle while the channel is not running. It therefore shapes the output from the first cycle of the next period and never changes a period in progress.
- R8: While lock (bit 6) is 1, writes to period, duty and the polarity bits leave the output waveform unchanged for any number of periods.
- R9: After a control write clears lock, the pending period, duty and polarity (including a polarity written in that same unlocking write) all take effect together on the first cycle after the next wrap, without the output being disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a locked update: a period and duty written mid-period while lock is set, then an unlocking write that also flips polarity, with the output still enabled. The bench reaches it by starting a running waveform, writing lock with the old polarity, writing a shorter period and duty and a locked polarity change, and then holding for several old-length periods before it clears lock with the new polarity. The bench keeps its own cycle-level model of the pending and working values, built from the requirements, and compares the output and the counter read-back on every cycle. This exposes any early, late or partial switch-over. An exhaustive sweep of small periods, duties and both polarities covers the compare boundaries, including duty 0 and duty at or above the period.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_PER  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DUTY = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'hC;

    // control word bit positions
    localparam int B_EN     = 0;
    localparam int B_MODE_L = 1;
    localparam int B_MODE_H = 2;
    localparam int B_ACTHI  = 3;
    localparam int B_IDLEHI = 4;
    localparam int B_LOCK   = 6;
    localparam int CTRL_W   = 9;

    localparam logic [1:0] MODE_CONT = 2'b01;

    typedef struct packed {
        logic       act_hi;
        logic       idle_hi;
    } pol_t;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        pol_t       pol;
        logic       lock;
    } ctrl_t;

    function automatic logic [CTRL_W-1:0] ctrl_pack(ctrl_t c);
        logic [CTRL_W-1:0] v;
        v                   = '0;
        v[B_EN]             = c.en;
        v[B_MODE_H:B_MODE_L]= c.mode;
        v[B_ACTHI]          = c.pol.act_hi;
        v[B_IDLEHI]         = c.pol.idle_hi;
        v[B_LOCK]           = c.lock;
        return v;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [CTRL_W-1:0] v);
        ctrl_t c;
        c.en          = v[B_EN];
        c.mode        = v[B_MODE_H:B_MODE_L];
        c.pol.act_hi  = v[B_ACTHI];
        c.pol.idle_hi = v[B_IDLEHI];
        c.lock        = v[B_LOCK];
        return c;
    endfunction

    function automatic logic ctrl_runs(ctrl_t c);
        return c.en && (c.mode == MODE_CONT);
    endfunction

endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  pend_period,
    output logic [CNT_W-1:0]  pend_duty,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  bus_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_period <= '0;
            pend_duty   <= '0;
            ctrl        <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_PER:  pend_period <= bus_wdata;
                OFS_DUTY: pend_duty   <= bus_wdata;
                OFS_CTRL: ctrl        <= ctrl_unpack(bus_wdata[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT:  bus_rdata = cnt;
            OFS_PER:  bus_rdata = pend_period;
            OFS_DUTY: bus_rdata = pend_duty;
            OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_pack(ctrl);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_lock_shadow.sv
module pwm_lock_shadow
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pend_period,
    input  logic [CNT_W-1:0] pend_duty,
    input  pol_t             pend_pol,
    input  logic             lock,
    input  logic             boundary,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_duty,
    output pol_t             act_pol
);

    logic take;
    assign take = boundary && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_period <= '0;
            act_duty   <= '0;
            act_pol    <= '0;
        end else if (take) begin
            act_period <= pend_period;
            act_duty   <= pend_duty;
            act_pol    <= pend_pol;
        end
    end

    // R8: a lock seen at an edge keeps the working set frozen across it
    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

    // R7: the working set only moves after a boundary seen with lock clear
    assert_load_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_period) || !$stable(act_duty) || !$stable(act_pol))
            |-> $past(boundary && !lock));

endmodule

// File: rtl/pwm_lock_core.sv
module pwm_lock_core
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             idle_level,
    input  logic [CNT_W-1:0] act_period,
    input  logic [CNT_W-1:0] act_duty,
    input  pol_t             act_pol,
    output logic [CNT_W-1:0] cnt,
    output logic             boundary,
    output logic             pwm_out
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_next;
    logic             wrap;

    assign cnt_next = {1'b0, cnt} + EXT_W'(1);
    assign wrap     = cnt_next >= {1'b0, act_period};
    assign boundary = !run || wrap;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (boundary) cnt <= '0;
        else               cnt <= cnt_next[CNT_W-1:0];
    end

    always_comb begin
        if (!run)                 pwm_out = idle_level;
        else if (cnt < act_duty)  pwm_out = act_pol.act_hi;
        else                      pwm_out = act_pol.idle_hi;
    end

    // R5: a nonzero count is always its predecessor plus one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

    // R5: while running the count stays inside the working period
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (run && act_period > 1) |-> (cnt < act_period));

    // R4: a stopped channel holds the count at zero
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pwm_lock_timer.sv
module pwm_lock_timer
    import pwm_lock_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              pwm_out
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pend_period;
    logic [CNT_W-1:0] pend_duty;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_duty;
    ctrl_t            ctrl;
    pol_t             act_pol;
    logic             boundary;
    logic             run;

    assign run = ctrl_runs(ctrl);

    pwm_lock_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt         (cnt),
        .pend_period (pend_period),
        .pend_duty   (pend_duty),
        .ctrl        (ctrl),
        .bus_rdata   (bus_rdata)
    );

    pwm_lock_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .pend_period (pend_period),
        .pend_duty   (pend_duty),
        .pend_pol    (ctrl.pol),
        .lock        (ctrl.lock),
        .boundary    (boundary),
        .act_period  (act_period),
        .act_duty    (act_duty),
        .act_pol     (act_pol)
    );

    pwm_lock_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .idle_level  (ctrl.pol.idle_hi),
        .act_period  (act_period),
        .act_duty    (act_duty),
        .act_pol     (act_pol),
        .cnt         (cnt),
        .boundary    (boundary),
        .pwm_out     (pwm_out)
    );

endmodule

// File: tb/sim_pwm_lock_timer.sv
module sim_pwm_lock_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = 4'h0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         pwm_out;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;
    string tag = "R1";

    // model state
    int       m_per, m_duty, m_aper, m_aduty, m_cnt;
    logic [8:0] m_ctrl;
    logic     m_aact, m_aidle;

    pwm_lock_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    function automatic bit m_run();
        return m_ctrl[0] && m_ctrl[2:1] == 2'b01;
    endfunction

    function automatic logic m_out();
        if (!m_run()) return m_ctrl[4];
        return (m_cnt < m_aduty) ? m_aact : m_aidle;
    endfunction

    // reference model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_per = 0; m_duty = 0; m_aper = 0; m_aduty = 0; m_cnt = 0;
            m_ctrl = '0; m_aact = 0; m_aidle = 0;
        end else begin
            bit bnd;
            bnd = !m_run() || (m_cnt + 1 >= m_aper);
            if (bnd && !m_ctrl[6]) begin
                m_aper = m_per; m_aduty = m_duty;
                m_aact = m_ctrl[3]; m_aidle = m_ctrl[4];
            end
            m_cnt = bnd ? 0 : m_cnt + 1;
            if (bus_wr) begin
                case (bus_addr)
                    4'h4: m_per  = int'(bus_wdata);
                    4'h8: m_duty = int'(bus_wdata);
                    4'hC: m_ctrl = bus_wdata[8:0] & 9'h05F;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // per-cycle monitor, sampled mid-high-phase
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            check(tag, int'(pwm_out), int'(m_out()));
            if (!bus_wr && bus_addr == 4'h0)
                check({tag, " R5 counter"}, int'(bus_rdata), m_cnt);
        end
    end

    task automatic wr(logic [3:0] a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = W'(d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
    endtask

    task automatic rd_check(string t, logic [3:0] a, int exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(t, int'(bus_rdata), exp);
        bus_addr = 4'h0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(4);
        @(negedge clk);
        #2;
        check("R1 out", int'(pwm_out), 0);
        rst = 1'b0;
        rd_check("R1 counter", 4'h0, 0);
        rd_check("R1 period", 4'h4, 0);
        rd_check("R1 duty", 4'h8, 0);
        rd_check("R1 ctrl", 4'hC, 0);

        // R2 register map
        wr(4'h4, 16'h1234); rd_check("R2 period", 4'h4, 16'h1234);
        wr(4'h8, 16'h0BCD); rd_check("R2 duty", 4'h8, 16'h0BCD);
        wr(4'h0, 16'hFFFF); rd_check("R2 counter ro", 4'h0, 0);
        wr(4'hC, 16'h0058); rd_check("R2 ctrl", 4'hC, 16'h0058);
        // R3 reserved bits read zero
        wr(4'hC, 16'hFFB4); rd_check("R3 reserved", 4'hC, 16'h0014);
        wr(4'hC, 16'h01A8); rd_check("R3 align lp", 4'hC, 16'h0008);

        mon_on = 1'b1;
        // R4 non-running modes drive bit 4 with counter held
        tag = "R4";
        wr(4'h4, 4); wr(4'h8, 2);
        wr(4'hC, 16'h0011); cycles(8);
        wr(4'hC, 16'h0017); cycles(8);
        wr(4'hC, 16'h0005); cycles(8);
        wr(4'hC, 16'h0000); cycles(4);

        // R5/R6 sweep of period, duty and polarity
        tag = "R6 sweep";
        for (int p = 0; p <= 6; p++) begin
            for (int d = 0; d <= 7; d++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    int pol;
                    pol = inv ? 16'h0010 : 16'h0008;
                    wr(4'hC, pol);
                    wr(4'h4, p); wr(4'h8, d);
                    cycles(1);
                    wr(4'hC, pol | 3);
                    cycles(2 * p + 3);
                end
            end
        end

        // R7 unlocked update lands only at wrap
        tag = "R7";
        wr(4'hC, 16'h0008); wr(4'h4, 6); wr(4'h8, 3);
        cycles(1); wr(4'hC, 16'h000B);
        cycles(8);
        wr(4'h4, 4); wr(4'h8, 1);
        cycles(14);
        wr(4'hC, 16'h0013);
        cycles(12);

        // R8 lock holds the waveform
        tag = "R8";
        wr(4'hC, 16'h000B); wr(4'h4, 5); wr(4'h8, 2);
        cycles(12);
        wr(4'hC, 16'h004B);
        wr(4'h4, 3); wr(4'h8, 1);
        wr(4'hC, 16'h0053);
        cycles(25);
        // R9 unlock with new polarity applies everything together
        tag = "R9";
        wr(4'hC, 16'h0013);
        cycles(20);
        rd_check("R9 ctrl", 4'hC, 16'h0013);

        mon_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule